// File: doc/BRIEF.md
# Double-Precision to Signed Word Converter

This block turns an IEEE-754 double-precision operand into a 32-bit two's-complement integer under a rounding mode chosen on each operation. The integer goes in the low half of a 64-bit result word, and the upper half is driven to zero. The block also returns five status flags for the operation: magnitude rounded up, fraction inexact, inexact, signaling-NaN invalid and invalid conversion. Folding these flags into any wider status register is left to the surrounding logic.

The operand is first classified as infinity, signaling NaN, quiet NaN, out of range (exponent too large), denormal or normal. A finite operand's significand is then shifted right so that its binary point sits below the integer LSB. Every bit shifted out is folded into a round bit (the last bit shifted out) and a sticky bit (the OR of all earlier ones). The selected mode decides whether the magnitude is incremented. A result that falls outside the signed 32-bit range saturates to the largest or smallest word, with its sign taken from the operand. One register stage follows the datapath by default, so a result appears one clock after its operand is presented.

Top module: `dbl2sw_cvt`

## Requirements
- R1: A NaN operand (exponent field all ones, fraction nonzero) gives 0x80000000 and raises flag_invalid. flag_snan is raised as well when the fraction MSB (op_bits[51]) is 0.
- R2: An infinity (exponent field all ones, fraction zero) gives 0x7FFFFFFF when positive and 0x80000000 when negative. It raises flag_invalid and leaves flag_snan clear.
- R3: A finite operand whose rounded value is above 2^31-1 or below -2^31 saturates to 0x7FFFFFFF or 0x80000000 by its sign and raises flag_invalid. This includes every biased exponent above 1054.
- R4: An in-range operand gives the integer rounded under rmode, with the encoding 00 nearest-even, 01 toward zero, 10 toward +infinity, 11 toward -infinity. Mode 01 never raises flag_rnd_up.
- R5: In mode 00, a value exactly halfway between two integers rounds to the even one. This holds for both signs.
- R6: result[63:32] is always zero, and result[31:0] holds the integer.
- R7: When no invalid condition occurs, flag_frac_inexact and flag_inexact are 1 exactly when discarded fraction bits were nonzero, and flag_rnd_up is 1 exactly when the magnitude was incremented. On an invalid conversion all three are 0.
- R8: While rst_n is low, out_valid, result and all flags are 0. Afterwards out_valid follows in_valid one clock later, and each result belongs to the operand presented in that earlier cycle.
- R9: ±0 gives 0 with no flags. A denormal gives 0 with the inexact flags set in modes 00 and 01, +1 in mode 10 when positive, and -1 (0xFFFFFFFF) in mode 11 when negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand present this cycle |
| op_bits | input | 64 | Double operand: bit 63 sign, bits 62:52 biased exponent, bits 51:0 fraction |
| rmode | input | 2 | Rounding mode: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| out_valid | output | 1 | Result and flags valid |
| result | output | 64 | Zero in the upper half, signed integer in the lower half |
| flag_rnd_up | output | 1 | Magnitude was incremented by rounding |
| flag_frac_inexact | output | 1 | Discarded fraction bits were nonzero |
| flag_inexact | output | 1 | Inexact exception condition |
| flag_snan | output | 1 | Operand was a signaling NaN |
| flag_invalid | output | 1 | Invalid conversion (NaN, infinity or out of range) |

## Verification
The bound checker watches the cross-stage relations on every cycle. It checks that special and over-large exponents always yield flag_invalid one cycle later, that a NaN always lands on the minimum word, and that a rounded-up result is always also flagged inexact. It also checks that truncation mode never rounds up, that zero never reports inexact, and that out_valid tracks in_valid with one cycle of delay. Exact rounded values, which need arithmetic on the whole operand, can only be confirmed by the bench scenarios. These cover halfway ties in each mode and sign, values just inside and outside ±2^31, denormals under directed modes, and random operands clustered around the representable range.

// File: rtl/dsw_pkg.sv
package dsw_pkg;

   typedef enum logic [1:0] {
      RM_NEAR = 2'b00,
      RM_ZERO = 2'b01,
      RM_PINF = 2'b10,
      RM_NINF = 2'b11
   } rmode_e;

   typedef struct packed {
      logic rnd_up;
      logic frac_inexact;
      logic inexact;
      logic snan_inv;
      logic cvt_inv;
   } cvt_flags_t;

endpackage

// File: rtl/dsw_classify.sv
module dsw_classify #(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   parameter int INT_W  = 32,
   parameter int SH_MAX = FRAC_W + 2,
   parameter int SH_W   = 6
) (
   input  logic [EXP_W+FRAC_W:0] op_bits,
   output logic                  sign,
   output logic                  is_nan,
   output logic                  is_snan,
   output logic                  is_inf,
   output logic                  is_big,
   output logic [FRAC_W:0]       sig,
   output logic [SH_W-1:0]       sh_amt
);
   localparam int BIAS = (1 << (EXP_W - 1)) - 1;
   localparam logic [EXP_W-1:0]   EXP_ONES = '1;
   localparam logic [EXP_W-1:0]   BIG_LIM  = EXP_W'(BIAS + INT_W);
   localparam logic [EXP_W+1:0]   SH_BASE  = (EXP_W + 2)'(FRAC_W + BIAS);
   localparam logic [EXP_W+1:0]   SH_CAP   = (EXP_W + 2)'(SH_MAX);

   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;
   logic [EXP_W-1:0]  exp_eff;
   logic [EXP_W+1:0]  raw_sh;
   logic              special;

   assign sign   = op_bits[EXP_W+FRAC_W];
   assign exp_f  = op_bits[EXP_W+FRAC_W-1:FRAC_W];
   assign frac_f = op_bits[FRAC_W-1:0];

   always_comb begin
      special = (exp_f == EXP_ONES);
      is_inf  = special && (frac_f == '0);
      is_nan  = special && (frac_f != '0);
      is_snan = is_nan && !frac_f[FRAC_W-1];
      is_big  = !special && (exp_f > BIG_LIM);
      // denormals share the smallest normal exponent but lose the hidden bit
      exp_eff = (exp_f == '0) ? EXP_W'(1) : exp_f;
      sig     = {(exp_f != '0), frac_f};
      raw_sh  = SH_BASE - {2'b00, exp_eff};
      if (exp_eff > SH_BASE[EXP_W-1:0] && SH_BASE[EXP_W+1:EXP_W] == 2'b00)
         sh_amt = SH_CAP[SH_W-1:0];
      else if (raw_sh > SH_CAP)
         sh_amt = SH_CAP[SH_W-1:0];
      else
         sh_amt = raw_sh[SH_W-1:0];
   end

endmodule

// File: rtl/dsw_align.sv
module dsw_align #(
   parameter int SIG_W  = 53,
   parameter int MAG_W  = 33,
   parameter int SH_MAX = 54,
   parameter int SH_W   = 6,
   parameter int STYLE  = 1
) (
   input  logic [SIG_W-1:0] sig,
   input  logic [SH_W-1:0]  sh_amt,
   output logic [MAG_W-1:0] mag,
   output logic             hi_nz,
   output logic             rnd,
   output logic             stk
);

   generate
      if (STYLE == 0) begin : g_flat
         // one wide shift; everything below the integer LSB is inspected at once
         localparam int XW = SIG_W + SH_MAX;
         logic [XW-1:0] ext;
         always_comb begin
            ext   = {sig, {SH_MAX{1'b0}}} >> sh_amt;
            mag   = ext[SH_MAX +: MAG_W];
            hi_nz = |ext[XW-1:SH_MAX+MAG_W];
            rnd   = ext[SH_MAX-1];
            stk   = |ext[SH_MAX-2:0];
         end
      end else begin : g_staged
         // logarithmic shifter; each stage folds the bits it drops into round/sticky
         logic [SH_W:0][SIG_W-1:0] v;
         logic [SH_W:0]            r;
         logic [SH_W:0]            s;
         assign v[0] = sig;
         assign r[0] = 1'b0;
         assign s[0] = 1'b0;
         for (genvar k = 0; k < SH_W; k++) begin : g_stage
            localparam int N = 1 << k;
            localparam logic [SIG_W-1:0] LOW = (SIG_W'(1) << (N - 1)) - SIG_W'(1);
            always_comb begin
               if (sh_amt[k]) begin
                  v[k+1] = v[k] >> N;
                  r[k+1] = v[k][N-1];
                  s[k+1] = s[k] | r[k] | (|(v[k] & LOW));
               end else begin
                  v[k+1] = v[k];
                  r[k+1] = r[k];
                  s[k+1] = s[k];
               end
            end
         end
         assign mag   = v[SH_W][MAG_W-1:0];
         assign hi_nz = |v[SH_W][SIG_W-1:MAG_W];
         assign rnd   = r[SH_W];
         assign stk   = s[SH_W];
      end
   endgenerate

endmodule

// File: rtl/dsw_round.sv
module dsw_round
   import dsw_pkg::*;
#(
   parameter int INT_W = 32
) (
   input  logic             sign,
   input  logic [INT_W:0]   mag,
   input  logic             hi_nz,
   input  logic             rnd,
   input  logic             stk,
   input  logic [1:0]       rmode,
   input  logic             is_nan,
   input  logic             is_snan,
   input  logic             is_inf,
   input  logic             is_big,
   output logic [INT_W-1:0] word,
   output cvt_flags_t       flags
);
   localparam logic [INT_W+1:0] NEG_LIM = {3'b001, {(INT_W-1){1'b0}}};
   localparam logic [INT_W+1:0] POS_LIM = NEG_LIM - 1'b1;
   localparam logic [INT_W-1:0] MIN_W   = {1'b1, {(INT_W-1){1'b0}}};
   localparam logic [INT_W-1:0] MAX_W   = ~MIN_W;

   logic             inc;
   logic             lost;
   logic [INT_W+1:0] sum;
   logic             ovf;
   logic             invalid;
   logic [INT_W-1:0] signed_w;

   always_comb begin
      lost = rnd | stk;
      unique case (rmode_e'(rmode))
         RM_NEAR: inc = rnd & (stk | mag[0]);
         RM_ZERO: inc = 1'b0;
         RM_PINF: inc = !sign & lost;
         RM_NINF: inc = sign & lost;
         default: inc = 1'b0;
      endcase
      sum      = {1'b0, mag} + {{(INT_W+1){1'b0}}, inc};
      ovf      = hi_nz | (sign ? (sum > NEG_LIM) : (sum > POS_LIM));
      invalid  = is_nan | is_inf | is_big | ovf;
      signed_w = sign ? (~sum[INT_W-1:0] + 1'b1) : sum[INT_W-1:0];

      if (is_nan)
         word = MIN_W;
      else if (is_inf | is_big | ovf)
         word = sign ? MIN_W : MAX_W;
      else
         word = signed_w;

      flags.rnd_up       = !invalid & inc;
      flags.frac_inexact = !invalid & lost;
      flags.inexact      = !invalid & lost;
      flags.snan_inv     = is_snan;
      flags.cvt_inv      = invalid;
   end

endmodule

// File: rtl/dbl2sw_cvt.sv
module dbl2sw_cvt
   import dsw_pkg::*;
#(
   parameter int EXP_W       = 11,
   parameter int FRAC_W      = 52,
   parameter int INT_W       = 32,
   parameter int ALIGN_STYLE = 1,
   parameter int OUT_REG     = 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [EXP_W+FRAC_W:0]  op_bits,
   input  logic [1:0]             rmode,
   output logic                   out_valid,
   output logic [2*INT_W-1:0]     result,
   output logic                   flag_rnd_up,
   output logic                   flag_frac_inexact,
   output logic                   flag_inexact,
   output logic                   flag_snan,
   output logic                   flag_invalid
);
   localparam int SIG_W  = FRAC_W + 1;
   localparam int MAG_W  = INT_W + 1;
   localparam int SH_MAX = SIG_W + 1;
   localparam int SH_W   = $clog2(SH_MAX + 1);
   localparam int BIAS   = (1 << (EXP_W - 1)) - 1;

   generate
      if (INT_W < 2 || INT_W >= FRAC_W) begin : g_bad_int
         $error("dbl2sw_cvt: INT_W must lie in [2, FRAC_W)");
      end
      if (EXP_W < 3 || BIAS + INT_W >= (1 << EXP_W) - 1) begin : g_bad_exp
         $error("dbl2sw_cvt: exponent field too narrow for INT_W");
      end
      if (ALIGN_STYLE != 0 && ALIGN_STYLE != 1) begin : g_bad_style
         $error("dbl2sw_cvt: ALIGN_STYLE must be 0 or 1");
      end
      if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_reg
         $error("dbl2sw_cvt: OUT_REG must be 0 or 1");
      end
   endgenerate

   logic              sign, is_nan, is_snan, is_inf, is_big;
   logic [SIG_W-1:0]  sig;
   logic [SH_W-1:0]   sh_amt;
   logic [MAG_W-1:0]  mag;
   logic              hi_nz, rnd, stk;
   logic [INT_W-1:0]  word;
   cvt_flags_t        flags;

   dsw_classify #(
      .EXP_W (EXP_W),
      .FRAC_W(FRAC_W),
      .INT_W (INT_W),
      .SH_MAX(SH_MAX),
      .SH_W  (SH_W)
   ) u_class (
      .op_bits(op_bits),
      .sign   (sign),
      .is_nan (is_nan),
      .is_snan(is_snan),
      .is_inf (is_inf),
      .is_big (is_big),
      .sig    (sig),
      .sh_amt (sh_amt)
   );

   dsw_align #(
      .SIG_W (SIG_W),
      .MAG_W (MAG_W),
      .SH_MAX(SH_MAX),
      .SH_W  (SH_W),
      .STYLE (ALIGN_STYLE)
   ) u_align (
      .sig   (sig),
      .sh_amt(sh_amt),
      .mag   (mag),
      .hi_nz (hi_nz),
      .rnd   (rnd),
      .stk   (stk)
   );

   dsw_round #(
      .INT_W(INT_W)
   ) u_round (
      .sign   (sign),
      .mag    (mag),
      .hi_nz  (hi_nz),
      .rnd    (rnd),
      .stk    (stk),
      .rmode  (rmode),
      .is_nan (is_nan),
      .is_snan(is_snan),
      .is_inf (is_inf),
      .is_big (is_big),
      .word   (word),
      .flags  (flags)
   );

   logic [INT_W-1:0] word_q;
   cvt_flags_t       flags_q;
   logic             valid_q;

   generate
      if (OUT_REG == 1) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               valid_q <= 1'b0;
               word_q  <= '0;
               flags_q <= '0;
            end else begin
               valid_q <= in_valid;
               word_q  <= word;
               flags_q <= flags;
            end
         end
      end else begin : g_comb
         assign valid_q = in_valid;
         assign word_q  = word;
         assign flags_q = flags;
      end
   endgenerate

   assign out_valid         = valid_q;
   assign result            = {{INT_W{1'b0}}, word_q};
   assign flag_rnd_up       = flags_q.rnd_up;
   assign flag_frac_inexact = flags_q.frac_inexact;
   assign flag_inexact      = flags_q.inexact;
   assign flag_snan         = flags_q.snan_inv;
   assign flag_invalid      = flags_q.cvt_inv;

endmodule

// File: rtl/dsw_chk.sv
module dsw_chk #(
   parameter int EXP_W   = 11,
   parameter int FRAC_W  = 52,
   parameter int INT_W   = 32,
   parameter int OUT_REG = 1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  in_valid,
   input logic [EXP_W+FRAC_W:0] op_bits,
   input logic [1:0]            rmode,
   input logic                  out_valid,
   input logic [INT_W-1:0]      res_lo,
   input logic                  flag_rnd_up,
   input logic                  flag_frac_inexact,
   input logic                  flag_inexact,
   input logic                  flag_snan,
   input logic                  flag_invalid
);
   localparam int BIAS = (1 << (EXP_W - 1)) - 1;
   localparam logic [EXP_W-1:0] EXP_ONES = '1;
   localparam logic [EXP_W-1:0] BIG_LIM  = EXP_W'(BIAS + INT_W);
   localparam logic [INT_W-1:0] MIN_W    = {1'b1, {(INT_W-1){1'b0}}};

   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;
   logic              sgn;
   assign sgn    = op_bits[EXP_W+FRAC_W];
   assign exp_f  = op_bits[EXP_W+FRAC_W-1:FRAC_W];
   assign frac_f = op_bits[FRAC_W-1:0];

   // output-only relations
   a_r1_snan_is_invalid: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && flag_snan |-> flag_invalid);
   a_r1_nan_min_word: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && flag_snan |-> res_lo == MIN_W);
   a_r7_up_needs_inexact: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && flag_rnd_up |-> flag_frac_inexact && flag_inexact);

   generate
      if (OUT_REG == 1) begin : g_seq
         a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
         a_r8_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
         a_r2_special_invalid: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && exp_f == EXP_ONES |=> flag_invalid);
         a_r2_pos_inf_max: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && exp_f == EXP_ONES && frac_f == '0 && !sgn |=> res_lo == ~MIN_W);
         a_r3_big_invalid: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && exp_f > BIG_LIM |=> flag_invalid);
         a_r4_trunc_no_up: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && rmode == 2'b01 |=> !flag_rnd_up);
         a_r9_zero_exact: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && exp_f == '0 && frac_f == '0 |=> res_lo == '0 && !flag_inexact);
      end else begin : g_comb
         a_r2_special_invalid: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && exp_f == EXP_ONES |-> flag_invalid);
         a_r2_pos_inf_max: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && exp_f == EXP_ONES && frac_f == '0 && !sgn |-> res_lo == ~MIN_W);
         a_r3_big_invalid: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && exp_f > BIG_LIM |-> flag_invalid);
         a_r4_trunc_no_up: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && rmode == 2'b01 |-> !flag_rnd_up);
         a_r9_zero_exact: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && exp_f == '0 && frac_f == '0 |-> res_lo == '0 && !flag_inexact);
      end
   endgenerate

endmodule

bind dbl2sw_cvt dsw_chk #(
   .EXP_W  (EXP_W),
   .FRAC_W (FRAC_W),
   .INT_W  (INT_W),
   .OUT_REG(OUT_REG)
) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .in_valid         (in_valid),
   .op_bits          (op_bits),
   .rmode            (rmode),
   .out_valid        (out_valid),
   .res_lo           (result[INT_W-1:0]),
   .flag_rnd_up      (flag_rnd_up),
   .flag_frac_inexact(flag_frac_inexact),
   .flag_inexact     (flag_inexact),
   .flag_snan        (flag_snan),
   .flag_invalid     (flag_invalid)
);

// File: tb/dbl2sw_cvt_test.sv
module dbl2sw_cvt_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] op_bits = '0;
   logic [1:0]  rmode = 2'b00;
   logic        out_valid;
   logic [63:0] result;
   logic        flag_rnd_up, flag_frac_inexact, flag_inexact, flag_snan, flag_invalid;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dbl2sw_cvt uut (
      .clk              (clk),
      .rst_n            (rst_n),
      .in_valid         (in_valid),
      .op_bits          (op_bits),
      .rmode            (rmode),
      .out_valid        (out_valid),
      .result           (result),
      .flag_rnd_up      (flag_rnd_up),
      .flag_frac_inexact(flag_frac_inexact),
      .flag_inexact     (flag_inexact),
      .flag_snan        (flag_snan),
      .flag_invalid     (flag_invalid)
   );

   // expected {word[31:0], rnd_up, frac_inexact, inexact, snan, invalid}
   function automatic logic [36:0] ref_model(input logic [63:0] op, input logic [1:0] rm);
      logic            sg;
      logic [10:0]     ex;
      logic [51:0]     fr;
      int              e, sh;
      longint unsigned sgf, ip, rem, half, mg;
      logic            nz, above, tie, inc;
      logic [31:0]     sat, val;
      sg  = op[63];
      ex  = op[62:52];
      fr  = op[51:0];
      sat = sg ? 32'h8000_0000 : 32'h7FFF_FFFF;
      if (ex == 11'h7FF) begin
         if (fr == 0) return {sat, 4'b0000, 1'b1};
         return {32'h8000_0000, 3'b000, ~fr[51], 1'b1};
      end
      e   = (ex == 0) ? -1022 : int'(ex) - 1023;
      if (e > 31) return {sat, 4'b0000, 1'b1};
      sgf = {11'd0, (ex != 0), fr};
      sh  = 52 - e;
      if (sh >= 64) begin
         ip = 0; nz = (sgf != 0); above = 1'b0; tie = 1'b0;
      end else begin
         ip    = sgf >> sh;
         rem   = sgf & ((64'd1 << sh) - 1);
         half  = 64'd1 << (sh - 1);
         nz    = (rem != 0);
         above = (rem > half);
         tie   = (rem == half);
      end
      case (rm)
         2'b00:   inc = above | (tie & ip[0]);
         2'b01:   inc = 1'b0;
         2'b10:   inc = !sg & nz;
         default: inc = sg & nz;
      endcase
      mg = ip + longint'(inc);
      if ((!sg && mg > 64'd2147483647) || (sg && mg > 64'd2147483648))
         return {sat, 4'b0000, 1'b1};
      val = sg ? (32'd0 - mg[31:0]) : mg[31:0];
      return {val, inc, nz, nz, 2'b00};
   endfunction

   function automatic string auto_tag(input logic [63:0] op, input logic [36:0] ex);
      if (op[62:52] == 11'h7FF) return (op[51:0] == 0) ? "R2" : "R1";
      if (ex[0]) return "R3";
      return "R4";
   endfunction

   task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic run_op(input logic [63:0] op, input logic [1:0] rm, input string tag);
      logic [36:0] ex;
      string       t;
      ex = ref_model(op, rm);
      t  = (tag == "") ? auto_tag(op, ex) : tag;
      @(negedge clk);
      in_valid = 1'b1;
      op_bits  = op;
      rmode    = rm;
      @(negedge clk);
      in_valid = 1'b0;
      check("R8", "out_valid", {63'd0, out_valid}, 64'd1);
      check(t, "word", {32'd0, result[31:0]}, {32'd0, ex[36:5]});
      check("R6", "upper half", {32'd0, result[63:32]}, 64'd0);
      check("R7", "rnd_up/frac_inexact/inexact",
            {61'd0, flag_rnd_up, flag_frac_inexact, flag_inexact}, {61'd0, ex[4:2]});
      check(t == "R2" ? "R2" : "R1", "snan flag", {63'd0, flag_snan}, {63'd0, ex[1]});
      check(t, "invalid flag", {63'd0, flag_invalid}, {63'd0, ex[0]});
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL R8 watchdog: actual hung expected completion");
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R8: reset state
      check("R8", "reset out_valid", {63'd0, out_valid}, 64'd0);
      check("R8", "reset result", result, 64'd0);
      check("R8", "reset flags",
            {59'd0, flag_rnd_up, flag_frac_inexact, flag_inexact, flag_snan, flag_invalid}, 64'd0);
      rst_n = 1'b1;

      // R9: zeros and denormals
      for (int m = 0; m < 4; m++) begin
         run_op(64'h0000_0000_0000_0000, 2'(m), "R9");
         run_op(64'h8000_0000_0000_0000, 2'(m), "R9");
         run_op(64'h0000_0000_0000_0001, 2'(m), "R9");
         run_op(64'h8000_0000_0000_0001, 2'(m), "R9");
         run_op(64'h000F_FFFF_FFFF_FFFF, 2'(m), "R9");
      end
      // R5: ties in every mode and sign
      for (int m = 0; m < 4; m++) begin
         run_op(64'h3FE0_0000_0000_0000, 2'(m), "R5");   // 0.5
         run_op(64'h3FF8_0000_0000_0000, 2'(m), "R5");   // 1.5
         run_op(64'h4004_0000_0000_0000, 2'(m), "R5");   // 2.5
         run_op(64'hC004_0000_0000_0000, 2'(m), "R5");   // -2.5
         run_op(64'hBFF8_0000_0000_0000, 2'(m), "R5");   // -1.5
      end
      // R3/R4: range boundaries
      for (int m = 0; m < 4; m++) begin
         run_op(64'h41DF_FFFF_FFC0_0000, 2'(m), "R4");   // 2^31-1
         run_op(64'h41DF_FFFF_FFE0_0000, 2'(m), "");     // 2^31-0.5
         run_op(64'h41E0_0000_0000_0000, 2'(m), "R3");   // 2^31
         run_op(64'hC1E0_0000_0000_0000, 2'(m), "R4");   // -2^31
         run_op(64'hC1E0_0000_0010_0000, 2'(m), "");     // -2^31-0.5
         run_op(64'hC1E0_0000_0020_0000, 2'(m), "R3");   // -2^31-1
         run_op(64'h43E0_0000_0000_0000, 2'(m), "R3");   // 2^63
         run_op(64'hFFEF_FFFF_FFFF_FFFF, 2'(m), "R3");   // most negative finite
      end
      // R1/R2: specials
      run_op(64'h7FF0_0000_0000_0000, 2'b00, "R2");
      run_op(64'hFFF0_0000_0000_0000, 2'b10, "R2");
      run_op(64'h7FF0_0000_0000_0001, 2'b01, "R1");
      run_op(64'hFFF4_0000_0000_0000, 2'b11, "R1");
      run_op(64'h7FF8_0000_0000_0000, 2'b00, "R1");
      run_op(64'hFFFF_FFFF_FFFF_FFFF, 2'b10, "R1");

      // R8: idle cycle after an operation
      @(negedge clk);
      check("R8", "idle out_valid", {63'd0, out_valid}, 64'd0);

      // random operands clustered near the integer range
      for (int i = 0; i < 4000; i++) begin
         logic [63:0] op;
         logic [10:0] ex;
         int          cls;
         op  = {$urandom, $urandom};
         cls = int'($urandom % 8);
         if (cls == 0) ex = op[62:52];
         else if (cls < 6) ex = 11'(1016 + ($urandom % 44));
         else if (cls == 6) ex = 11'(1052 + ($urandom % 4));
         else ex = 11'($urandom % 2) * 11'h7FF;
         op[62:52] = ex;
         if ($urandom % 3 == 0) op[30:0] = '0;   // favour exact halves
         run_op(op, 2'($urandom % 4), "");
      end

      done = 1'b1;
      finish_run();
   end

endmodule